// File: doc/BRIEF.md
# Fuse Bit Programming Sequencer

This block burns one-time-programmable fuses one bit at a time on behalf of a register interface. Software writes a 16-bit command word that holds an unlock key, a byte index and a bit index. If the key matches and the byte index names a fuse byte that exists, the block raises a program strobe toward the fuse array for the chosen bit. The strobe is held for a fixed, parameterised number of clock cycles. At a 12 MHz clock this is at least 120000 cycles, which gives the 10 ms burn time a fuse needs. Several bits need several commands.

Fuse contents are not visible directly. A read strobe copies the current fuse byte into a shadow register on the next clock edge. Software can therefore confirm a burn by issuing a read after the strobe has ended. The block reports three flags: busy while a strobe is active, done once the last strobe has completed, and a sticky error flag for commands that arrive while a strobe is active. Fuse bits only ever go from 0 to 1. The fuse array itself is a behavioural model that lives in the bench.

Top module: `fuse_prog_ctrl`

## Requirements
- R1: A write is accepted only when command bits 15..8 equal 8'hBD. A write with any other key raises no strobe and leaves the fuses unchanged.
- R2: Command bits 2..0 give the bit index n (0..7). `fuse_bit_o` carries n for the whole strobe, and fuse bit n reads back as 1 afterwards.
- R3: Command bits 5..4 give the byte index. Only byte 0 exists, so a byte index of 1, 2 or 3 makes the write rejected with no strobe.
- R4: Each accepted command sets exactly one bit. The bit index is stable while the strobe is high, and no other fuse bit changes.
- R5: An accepted write raises `fuse_pgm_o` and `busy_o` on the next edge. Both stay high for exactly PULSE_CYCLES clock cycles.
- R6: `done_o` goes high in the cycle in which the strobe ends. It clears when the next command is accepted.
- R7: A read strobe loads `shadow_o` with `fuse_byte_i` on the next edge. This also happens while a strobe is running or when a write arrives in the same cycle; in that case the shadow captures the pre-burn value.
- R8: A write that arrives while `busy_o` is high is ignored: the strobe and bit index are unchanged. It sets `err_o`, which stays set until reset.
- R9: Programming a bit that is already 1 still runs the full strobe and changes nothing else in the fuse byte.
- R10: Synchronous reset clears `busy_o`, `done_o`, `err_o` and `fuse_pgm_o`, and aborts any running strobe. It leaves `shadow_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | One-cycle command write strobe |
| reg_wdata_i | input | 16 | Command word: key 15..8, byte 5..4, bit 2..0 |
| reg_rd_i | input | 1 | One-cycle read strobe that refreshes the shadow byte |
| shadow_o | output | 8 | Last captured fuse byte |
| busy_o | output | 1 | Strobe in progress |
| done_o | output | 1 | Last strobe completed |
| err_o | output | 1 | Sticky flag: command arrived while busy |
| fuse_pgm_o | output | 1 | Program strobe to the fuse array |
| fuse_bit_o | output | 3 | Bit index being programmed |
| fuse_byte_i | input | 8 | Current fuse byte from the array |

## Verification
A read refresh and a program acceptance can land on the same clock edge. The bench provokes this by raising both strobes in one cycle for a bit that is still 0. It judges the result by requiring the shadow to hold the pre-burn byte at once, and the burned bit to appear only in a read issued after the strobe ends. A second same-cycle case is a good-key command that arrives mid-strobe. The bench judges it by checking that the bit index holds, the error flag sets, and only the first bit shows up in the next read.

// File: rtl/fuse_prog_pkg.sv
package fuse_prog_pkg;

  localparam logic [7:0] PROG_KEY = 8'hBD;

  // Command word layout; field positions are part of the register contract.
  typedef struct packed {
    logic [7:0] key;
    logic [1:0] rsvd_hi;
    logic [1:0] byte_sel;
    logic       rsvd_lo;
    logic [2:0] bit_sel;
  } prog_cmd_t;

endpackage

// File: rtl/fuse_cmd_decode.sv
module fuse_cmd_decode
  import fuse_prog_pkg::*;
#(
  parameter logic [7:0] KEY       = PROG_KEY,
  parameter int         NUM_BYTES = 1
) (
  input  logic [15:0] wdata_i,
  output logic        key_ok_o,
  output logic        byte_ok_o,
  output logic [2:0]  bit_o
);

  prog_cmd_t cmd;

  always_comb begin
    cmd       = prog_cmd_t'(wdata_i);
    key_ok_o  = (cmd.key == KEY);
    byte_ok_o = (32'(cmd.byte_sel) < NUM_BYTES);
    bit_o     = cmd.bit_sel;
  end

endmodule

// File: rtl/fuse_pulse_timer.sv
module fuse_pulse_timer #(
  parameter int PULSE_CYCLES = 120000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic active_o,
  output logic last_o
);

  localparam int CNT_W = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_o) begin
      cnt_q <= '0;
      if (start_i) active_o <= 1'b1;
    end else if (cnt_q == LAST) begin
      active_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = active_o && (cnt_q == LAST);

  // R5: the counter never runs past its terminal value while a pulse is active
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (cnt_q <= LAST));

endmodule

// File: rtl/fuse_shadow.sv
module fuse_shadow #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);

  // Deliberately not reset: contents survive a controller reset.
  always_ff @(posedge clk) begin
    if (load_i) q_o <= data_i;
  end

endmodule

// File: rtl/fuse_prog_ctrl.sv
module fuse_prog_ctrl
  import fuse_prog_pkg::*;
#(
  parameter int         PULSE_CYCLES = 120000,
  parameter logic [7:0] KEY          = PROG_KEY,
  parameter int         NUM_BYTES    = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_i,
  input  logic [15:0] reg_wdata_i,
  input  logic        reg_rd_i,
  output logic [7:0]  shadow_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic        fuse_pgm_o,
  output logic [2:0]  fuse_bit_o,
  input  logic [7:0]  fuse_byte_i
);

  logic       key_ok, byte_ok, accept, active, last;
  logic [2:0] cmd_bit;

  fuse_cmd_decode #(.KEY(KEY), .NUM_BYTES(NUM_BYTES)) u_dec (
    .wdata_i  (reg_wdata_i),
    .key_ok_o (key_ok),
    .byte_ok_o(byte_ok),
    .bit_o    (cmd_bit)
  );

  assign accept = reg_wr_i && key_ok && byte_ok && !active;

  fuse_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start_i (accept),
    .active_o(active),
    .last_o  (last)
  );

  fuse_shadow #(.WIDTH(8)) u_shd (
    .clk   (clk),
    .load_i(reg_rd_i),
    .data_i(fuse_byte_i),
    .q_o   (shadow_o)
  );

  assign busy_o     = active;
  assign fuse_pgm_o = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      fuse_bit_o <= '0;
    end else begin
      if (accept)             fuse_bit_o <= cmd_bit;
      if (accept)             done_o <= 1'b0;
      else if (last)          done_o <= 1'b1;
      if (reg_wr_i && active) err_o  <= 1'b1;
    end
  end

  // R1: a rising strobe follows a write carrying the key
  p_key_gate_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(fuse_pgm_o) |-> ($past(reg_wr_i) && ($past(reg_wdata_i[15:8]) == KEY)));

  // R3: a rising strobe follows a write naming an existing byte
  p_byte_gate_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fuse_pgm_o) |-> (32'($past(reg_wdata_i[5:4])) < NUM_BYTES));

  // R4: bit index holds for the whole strobe
  p_bit_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (fuse_pgm_o && $past(fuse_pgm_o)) |-> $stable(fuse_bit_o));

  // R6: strobe end raises done
  p_done_on_end_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && !$past(rst)) |-> done_o);

  // R7: read strobe refreshes the shadow on the next edge
  p_shadow_load_r7: assert property (@(posedge clk) disable iff (rst)
    reg_rd_i |=> (shadow_o == $past(fuse_byte_i)));

  // R8: a write during a strobe sets the sticky error
  p_busy_err_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && reg_wr_i) |=> err_o);

  // R10: reset leaves all flags low
  p_reset_flags_r10: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && !done_o && !err_o && !fuse_pgm_o));

endmodule

// File: tb/fuse_prog_ctrl_test.sv
module fuse_prog_ctrl_test;

  localparam int         PULSE = 8;
  localparam logic [7:0] KEY   = 8'hBD;

  logic        clk = 1'b0;
  logic        rst, wr, rd;
  logic [15:0] wdata;
  logic [7:0]  shadow, fuse_q;
  logic        busy, done, err, fuse_pgm;
  logic [2:0]  fuse_bit;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] expb = 8'h00;

  always #2 clk = ~clk;

  fuse_prog_ctrl #(.PULSE_CYCLES(PULSE)) uut (
    .clk(clk), .rst(rst), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
    .shadow_o(shadow), .busy_o(busy), .done_o(done), .err_o(err),
    .fuse_pgm_o(fuse_pgm), .fuse_bit_o(fuse_bit), .fuse_byte_i(fuse_q)
  );

  // Behavioural fuse array: a bit is set only after a strobe of full length.
  int         run_len = 0, last_len = 0;
  logic [2:0] run_bit = '0;
  initial fuse_q = 8'h00;
  always @(posedge clk) begin
    if (fuse_pgm) begin
      run_len <= run_len + 1;
      run_bit <= fuse_bit;
    end else if (run_len != 0) begin
      if (run_len >= PULSE) fuse_q[run_bit] <= 1'b1;
      last_len <= run_len;
      run_len  <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [7:0] k, input logic [1:0] b, input logic [2:0] n);
    return {k, 2'b00, b, 1'b0, n};
  endfunction

  task automatic issue(input logic [15:0] d, input logic also_rd);
    @(negedge clk); wr = 1'b1; wdata = d; rd = also_rd;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic run_prog(input logic [2:0] n);
    issue(mk(KEY, 2'd0, n), 1'b0);
    chk("R5 busy after accept", busy, 1);
    chk("R6 done cleared on accept", done, 0);
    chk("R2 bit index", fuse_bit, n);
    for (int i = 1; i < PULSE; i++) begin
      @(negedge clk);
      chk("R5 busy held", busy, 1);
      chk("R4 bit stable", fuse_bit, n);
    end
    @(negedge clk);
    chk("R5 strobe ends", fuse_pgm, 0);
    chk("R6 done set", done, 1);
    settle();
    chk("R5 strobe length", last_len, PULSE);
    expb[n] = 1'b1;
    do_read();
    chk("R2 R4 R9 fuse byte", shadow, expb);
  endtask

  initial begin
    rst = 1'b1; wr = 1'b0; rd = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 busy reset", busy, 0);
    chk("R10 done reset", done, 0);
    chk("R10 err reset", err, 0);
    chk("R10 strobe reset", fuse_pgm, 0);
    do_read();
    chk("R7 initial shadow", shadow, 8'h00);

    // R1: sweep every wrong key
    for (int k = 0; k < 256; k++) begin
      if (k != KEY) begin
        issue(mk(8'(k), 2'd0, 3'd3), 1'b0);
        chk("R1 wrong key no strobe", fuse_pgm, 0);
      end
    end
    // R3: nonexistent bytes
    for (int b = 1; b < 4; b++) begin
      issue(mk(KEY, 2'(b), 3'd2), 1'b0);
      chk("R3 bad byte no strobe", busy, 0);
    end
    settle();
    do_read();
    chk("R1 R3 fuses untouched", shadow, 8'h00);
    chk("R1 R3 no error", err, 0);

    // R7: read and program in the same cycle
    issue(mk(KEY, 2'd0, 3'd5), 1'b1);
    chk("R7 same-cycle shadow pre-burn", shadow, 8'h00);
    chk("R7 same-cycle accept", busy, 1);
    while (busy) @(negedge clk);
    settle();
    expb[5] = 1'b1;
    do_read();
    chk("R7 post-burn read", shadow, expb);

    // R8: command during a strobe
    issue(mk(KEY, 2'd0, 3'd0), 1'b0);
    @(negedge clk);
    issue(mk(KEY, 2'd0, 3'd1), 1'b0);
    chk("R8 err set", err, 1);
    chk("R8 bit index kept", fuse_bit, 0);
    while (busy) @(negedge clk);
    settle();
    chk("R8 err sticky", err, 1);
    expb[0] = 1'b1;
    do_read();
    chk("R8 R4 only first bit", shadow, expb);

    // R10: reset mid-strobe
    issue(mk(KEY, 2'd0, 3'd6), 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 busy cleared", busy, 0);
    chk("R10 err cleared", err, 0);
    chk("R10 done cleared", done, 0);
    chk("R10 shadow kept", shadow, expb);
    repeat (PULSE + 3) @(negedge clk);
    do_read();
    chk("R10 aborted burn no effect", shadow, expb);

    // R2 R9: sweep every bit, including ones already set
    for (int n = 0; n < 8; n++) run_prog(3'(n));
    run_prog(3'd5);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule